// File: doc/BRIEF.md
# Delta PCM Sample Playback Channel

This block plays 1-bit delta-modulated audio samples held in memory. Software programs a sample start address, a sample length, a playback rate and two control flags (loop and interrupt enable), then enables the channel. A memory reader fetches sample bytes one at a time through a request/grant handshake that stands in for a CPU-stalling DMA read. Each fetched byte is held in a one-byte buffer until the output unit takes it into an 8-bit shift register. The output unit then moves a 7-bit output level up or down by 2 for every bit, at a rate set by a programmable timer.

When the last byte of a sample has been fetched, the reader either restarts from the start address (loop set) or stops. If loop is clear and interrupt enable is set, it raises an interrupt flag. A direct-load register sets the output level at once, which is how raw PCM is written. A status output reports whether bytes remain to be fetched. The bus arbiter and the CPU sit outside the block.

Top module: `dpcm_channel`

## Requirements
- R1: After synchronous reset the level output is 0, no DMA request is raised, the IRQ flag is clear and the active status is low.
- R2: A register write with reg_sel = 1 loads reg_wdata[6:0] into the level output on the next clock edge, and takes priority over any bit step in that cycle.
- R3: Enabling the channel (en_wr with en_val = 1) while no bytes remain loads the fetch address with 0xC000 + 64 × (reg_sel = 2 value) and the byte count with 16 × (reg_sel = 3 value) + 1. Exactly that many bytes are fetched. The active output is high exactly while the byte count is nonzero.
- R4: dma_req is high whenever the sample buffer is empty and the byte count is nonzero. Until the grant arrives, dma_req and dma_addr hold steady. The grant cycle carries the data byte.
- R5: Each completed fetch advances the address by one, wrapping from 0xFFFF to 0x8000, and decrements the byte count.
- R6: Bits of a sample byte are applied least significant bit first. A 1 adds 2 to the level and a 0 subtracts 2, and a step that would leave the range 0 to 127 is skipped.
- R7: When the final byte is fetched with loop clear and IRQ enable set, irq goes high. A control write that keeps IRQ enable set does not clear it. Any enable write (en_wr) clears it.
- R8: When the final byte is fetched with loop set, the address and byte count restart from the programmed values and irq stays low.
- R9: The control register (reg_sel = 0) holds IRQ enable in bit 7, loop in bit 6 and the rate index in bits 3:0. The index selects a bit period of 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72 or 54 cycles (index 0 to 15), shifted right by TIMER_SHIFT.
- R10: Disabling the channel (en_wr with en_val = 0) clears the byte count at once, so fetching stops. The byte in the shift register and any byte already buffered still play out.
- R11: A control write with IRQ enable clear also clears a pending irq.
- R12: An output cycle lasts 8 bits. At its start the shift register reloads from the buffer if the buffer is full; if the buffer is empty, the cycle is silent and the level is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 direct level, 2 start address, 3 length |
| reg_wdata | input | 8 | Register write data |
| en_wr | input | 1 | Enable register write strobe |
| en_val | input | 1 | Enable value written with en_wr |
| dma_req | output | 1 | Sample byte fetch request |
| dma_addr | output | 16 | Fetch address |
| dma_gnt | input | 1 | Fetch grant; dma_data is valid in this cycle |
| dma_data | input | 8 | Fetched sample byte |
| level | output | 7 | Current output level |
| active | output | 1 | High while sample bytes remain to be fetched |
| irq | output | 1 | End-of-sample interrupt flag |

## Verification
The bench builds the channel with TIMER_SHIFT = 3 and keeps the default address and length scaling. This gives bit periods of 6 and 10 cycles for rate indices 15 and 13. A 65-byte sample that wraps from 0xFFFF to 0x8000, a 17-byte sample that drives the level into its upper clamp, and several looping passes all fit well inside the run. Those two indices are measured exactly as the spacing between consecutive level steps. Because the full address and length arithmetic stays at its default values, the start address, wrap point and byte counts are checked exactly as specified.

// File: rtl/dpcm_pkg.sv
package dpcm_pkg;

    localparam int SAMPLE_W = 8;
    localparam int RATE_W   = 4;
    localparam int PERIOD_W = 9;
    localparam int BITCNT_W = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LEVEL = 2'd1,
        SEL_ADDR  = 2'd2,
        SEL_LEN   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              irq_en;
        logic              loop;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] bits;
        logic [BITCNT_W-1:0] left;
        logic                silent;
    } shifter_t;

    // Bit period in clock cycles for each rate index.
    function automatic logic [PERIOD_W-1:0] rate_period(input logic [RATE_W-1:0] idx);
        logic [PERIOD_W-1:0] p;
        case (idx)
            4'd0:    p = 9'd428;
            4'd1:    p = 9'd380;
            4'd2:    p = 9'd340;
            4'd3:    p = 9'd320;
            4'd4:    p = 9'd286;
            4'd5:    p = 9'd254;
            4'd6:    p = 9'd226;
            4'd7:    p = 9'd214;
            4'd8:    p = 9'd190;
            4'd9:    p = 9'd160;
            4'd10:   p = 9'd142;
            4'd11:   p = 9'd128;
            4'd12:   p = 9'd106;
            4'd13:   p = 9'd84;
            4'd14:   p = 9'd72;
            default: p = 9'd54;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dpcm_regs.sv
module dpcm_regs
    import dpcm_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [1:0]          sel,
    input  logic [SAMPLE_W-1:0] wdata,
    output ctrl_t               ctrl,
    output logic [SAMPLE_W-1:0] addr_reg,
    output logic [SAMPLE_W-1:0] len_reg,
    output logic                lvl_load,
    output logic [LVL_W-1:0]    lvl_val,
    output logic                irq_clr
);

    reg_sel_e sel_e;
    ctrl_t    ctrl_new;

    assign sel_e = reg_sel_e'(sel);

    always_comb begin
        ctrl_new.irq_en = wdata[SAMPLE_W-1];
        ctrl_new.loop   = wdata[SAMPLE_W-2];
        ctrl_new.rate   = wdata[RATE_W-1:0];
    end

    assign lvl_load = wr && (sel_e == SEL_LEVEL);
    assign lvl_val  = wdata[LVL_W-1:0];
    assign irq_clr  = wr && (sel_e == SEL_CTRL) && !ctrl_new.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            addr_reg <= '0;
            len_reg  <= '0;
        end else if (wr) begin
            case (sel_e)
                SEL_CTRL: ctrl     <= ctrl_new;
                SEL_ADDR: addr_reg <= wdata;
                SEL_LEN:  len_reg  <= wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/dpcm_reader.sv
module dpcm_reader
    import dpcm_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] ADDR_BASE  = 16'hC000,
    parameter logic [ADDR_W-1:0] WRAP_ADDR  = 16'h8000,
    parameter int                ADDR_SHIFT = 6,
    parameter int                LEN_SHIFT  = 4,
    parameter int                REM_W      = SAMPLE_W + LEN_SHIFT + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                loop,
    input  logic                irq_en,
    input  logic [SAMPLE_W-1:0] addr_reg,
    input  logic [SAMPLE_W-1:0] len_reg,
    input  logic                en_wr,
    input  logic                en_val,
    input  logic                irq_clr,
    input  logic                dma_gnt,
    input  logic [SAMPLE_W-1:0] dma_data,
    input  logic                buf_take,
    output logic                dma_req,
    output logic [ADDR_W-1:0]   dma_addr,
    output logic                buf_full,
    output logic [SAMPLE_W-1:0] buf_data,
    output logic [REM_W-1:0]    rem,
    output logic                irq
);

    logic [ADDR_W-1:0] cur_addr, addr_n, start_addr;
    logic [REM_W-1:0]  rem_n, start_len;
    logic              fetch, irq_set;

    assign start_addr = ADDR_BASE + (ADDR_W'(addr_reg) << ADDR_SHIFT);
    assign start_len  = (REM_W'(len_reg) << LEN_SHIFT) + REM_W'(1);

    assign dma_req  = !buf_full && (rem != '0);
    assign dma_addr = cur_addr;
    assign fetch    = dma_req && dma_gnt;

    always_comb begin
        addr_n  = cur_addr;
        rem_n   = rem;
        irq_set = 1'b0;
        if (fetch) begin
            addr_n = (cur_addr == '1) ? WRAP_ADDR : cur_addr + 1'b1;
            rem_n  = rem - 1'b1;
            if (rem == REM_W'(1)) begin
                if (loop) begin
                    addr_n = start_addr;
                    rem_n  = start_len;
                end else if (irq_en) begin
                    irq_set = 1'b1;
                end
            end
        end
        if (en_wr) begin
            if (!en_val) begin
                rem_n = '0;
            end else if (rem == '0) begin
                addr_n = start_addr;
                rem_n  = start_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            rem      <= '0;
            buf_full <= 1'b0;
            buf_data <= '0;
            irq      <= 1'b0;
        end else begin
            cur_addr <= addr_n;
            rem      <= rem_n;
            if (fetch) begin
                buf_data <= dma_data;
                buf_full <= 1'b1;
            end else if (buf_take) begin
                buf_full <= 1'b0;
            end
            if (irq_set) begin
                irq <= 1'b1;
            end else if (en_wr || irq_clr) begin
                irq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dpcm_output.sv
module dpcm_output
    import dpcm_pkg::*;
#(
    parameter int LVL_W       = 7,
    parameter int STEP        = 2,
    parameter int TIMER_SHIFT = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RATE_W-1:0]   rate,
    input  logic                buf_full,
    input  logic [SAMPLE_W-1:0] buf_data,
    input  logic                lvl_load,
    input  logic [LVL_W-1:0]    lvl_val,
    output logic                buf_take,
    output logic [LVL_W-1:0]    level
);

    localparam logic [LVL_W:0] STEP_V = (LVL_W+1)'(STEP);
    localparam logic [LVL_W:0] MAX_V  = {1'b0, {LVL_W{1'b1}}};

    logic [PERIOD_W-1:0] tmr, period;
    logic                tick;
    shifter_t            sh, sh_n;
    logic [LVL_W-1:0]    level_n;

    function automatic logic [LVL_W-1:0] nudge(input logic [LVL_W-1:0] cur, input logic up);
        logic [LVL_W:0] wide;
        logic [LVL_W-1:0] res;
        wide = {1'b0, cur};
        res  = cur;
        if (up) begin
            if (wide + STEP_V <= MAX_V) res = LVL_W'(wide + STEP_V);
        end else begin
            if (wide >= STEP_V) res = LVL_W'(wide - STEP_V);
        end
        return res;
    endfunction

    always_comb begin
        period = rate_period(rate) >> TIMER_SHIFT;
        if (period == '0) period = PERIOD_W'(1);
    end

    assign tick = (tmr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr <= '0;
        end else if (tick) begin
            tmr <= period - 1'b1;
        end else begin
            tmr <= tmr - 1'b1;
        end
    end

    always_comb begin
        sh_n     = sh;
        level_n  = level;
        buf_take = 1'b0;
        if (tick) begin
            if (!sh.silent) level_n = nudge(level, sh.bits[0]);
            sh_n.bits = sh.bits >> 1;
            if (sh.left == '0) begin
                sh_n.left = BITCNT_W'(SAMPLE_W - 1);
                if (buf_full) begin
                    sh_n.bits   = buf_data;
                    sh_n.silent = 1'b0;
                    buf_take    = 1'b1;
                end else begin
                    sh_n.silent = 1'b1;
                end
            end else begin
                sh_n.left = sh.left - 1'b1;
            end
        end
        if (lvl_load) level_n = lvl_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh.bits   <= '0;
            sh.left   <= '0;
            sh.silent <= 1'b1;
            level     <= '0;
        end else begin
            sh    <= sh_n;
            level <= level_n;
        end
    end

endmodule

// File: rtl/dpcm_channel.sv
module dpcm_channel
    import dpcm_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                LVL_W       = 7,
    parameter int                STEP        = 2,
    parameter int                TIMER_SHIFT = 0,
    parameter logic [ADDR_W-1:0] ADDR_BASE   = 16'hC000,
    parameter logic [ADDR_W-1:0] WRAP_ADDR   = 16'h8000,
    parameter int                ADDR_SHIFT  = 6,
    parameter int                LEN_SHIFT   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [1:0]          reg_sel,
    input  logic [SAMPLE_W-1:0] reg_wdata,
    input  logic                en_wr,
    input  logic                en_val,
    output logic                dma_req,
    output logic [ADDR_W-1:0]   dma_addr,
    input  logic                dma_gnt,
    input  logic [SAMPLE_W-1:0] dma_data,
    output logic [LVL_W-1:0]    level,
    output logic                active,
    output logic                irq
);

    localparam int REM_W = SAMPLE_W + LEN_SHIFT + 1;

    ctrl_t               ctrl;
    logic [SAMPLE_W-1:0] addr_reg, len_reg, buf_data;
    logic                lvl_load, irq_clr, buf_full, buf_take;
    logic [LVL_W-1:0]    lvl_val;
    logic [REM_W-1:0]    bytes_rem;

    dpcm_regs #(.LVL_W(LVL_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .ctrl     (ctrl),
        .addr_reg (addr_reg),
        .len_reg  (len_reg),
        .lvl_load (lvl_load),
        .lvl_val  (lvl_val),
        .irq_clr  (irq_clr)
    );

    dpcm_reader #(
        .ADDR_W     (ADDR_W),
        .ADDR_BASE  (ADDR_BASE),
        .WRAP_ADDR  (WRAP_ADDR),
        .ADDR_SHIFT (ADDR_SHIFT),
        .LEN_SHIFT  (LEN_SHIFT),
        .REM_W      (REM_W)
    ) u_reader (
        .clk      (clk),
        .rst      (rst),
        .loop     (ctrl.loop),
        .irq_en   (ctrl.irq_en),
        .addr_reg (addr_reg),
        .len_reg  (len_reg),
        .en_wr    (en_wr),
        .en_val   (en_val),
        .irq_clr  (irq_clr),
        .dma_gnt  (dma_gnt),
        .dma_data (dma_data),
        .buf_take (buf_take),
        .dma_req  (dma_req),
        .dma_addr (dma_addr),
        .buf_full (buf_full),
        .buf_data (buf_data),
        .rem      (bytes_rem),
        .irq      (irq)
    );

    dpcm_output #(
        .LVL_W       (LVL_W),
        .STEP        (STEP),
        .TIMER_SHIFT (TIMER_SHIFT)
    ) u_output (
        .clk      (clk),
        .rst      (rst),
        .rate     (ctrl.rate),
        .buf_full (buf_full),
        .buf_data (buf_data),
        .lvl_load (lvl_load),
        .lvl_val  (lvl_val),
        .buf_take (buf_take),
        .level    (level)
    );

    assign active = (bytes_rem != '0);

endmodule

// File: rtl/dpcm_channel_chk.sv
module dpcm_channel_chk #(
    parameter int          ADDR_W    = 16,
    parameter int          LVL_W     = 7,
    parameter int          STEP      = 2,
    parameter int          REM_W     = 13,
    parameter logic [15:0] WRAP_ADDR = 16'h8000
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic              wdata_msb,
    input logic              en_wr,
    input logic              dma_req,
    input logic              dma_gnt,
    input logic [ADDR_W-1:0] dma_addr,
    input logic [LVL_W-1:0]  level,
    input logic              irq,
    input logic [REM_W-1:0]  bytes_rem
);

    // R4: an unanswered request stays up with a steady address
    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !dma_gnt && !en_wr) |=> (dma_req && $stable(dma_addr)));

    // R5: a fetch from the top address continues at the wrap address
    p_addr_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (dma_req && dma_gnt && (dma_addr == '1) && (bytes_rem > REM_W'(1)) && !en_wr)
        |=> (dma_addr == ADDR_W'(WRAP_ADDR)));

    // R6: without a direct load the level moves by zero or one step
    p_level_step_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr && (reg_sel == 2'd1)) |->
        ((int'(level) == int'($past(level))) ||
         (int'(level) == int'($past(level)) + STEP) ||
         (int'(level) == int'($past(level)) - STEP)));

    // R7: a pending interrupt survives until an enable write or a clearing control write
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && !en_wr && !(reg_wr && (reg_sel == 2'd0) && !wdata_msb)) |=> irq);

    // R7: the interrupt only rises right after a completed fetch
    p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(dma_req && dma_gnt));

    // R4: nothing is requested once the byte count is exhausted
    p_no_req_done_r4: assert property (@(posedge clk) disable iff (rst)
        ((bytes_rem == '0) && !en_wr) |=> !dma_req || (bytes_rem != '0));

endmodule

bind dpcm_channel dpcm_channel_chk #(
    .ADDR_W    (ADDR_W),
    .LVL_W     (LVL_W),
    .STEP      (STEP),
    .REM_W     (REM_W),
    .WRAP_ADDR (16'(WRAP_ADDR))
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .wdata_msb (reg_wdata[7]),
    .en_wr     (en_wr),
    .dma_req   (dma_req),
    .dma_gnt   (dma_gnt),
    .dma_addr  (dma_addr),
    .level     (level),
    .irq       (irq),
    .bytes_rem (bytes_rem)
);

// File: tb/dpcm_channel_tb.sv
`timescale 1ns/1ps
module dpcm_channel_tb;

    localparam int TSH = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        en_wr = 1'b0;
    logic        en_val = 1'b0;
    logic        dma_gnt = 1'b0;
    logic [7:0]  dma_data = 8'd0;
    logic        dma_req;
    logic [15:0] dma_addr;
    logic [6:0]  level;
    logic        active;
    logic        irq;

    dpcm_channel #(.TIMER_SHIFT(TSH)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .en_wr(en_wr), .en_val(en_val), .dma_req(dma_req), .dma_addr(dma_addr),
        .dma_gnt(dma_gnt), .dma_data(dma_data), .level(level), .active(active), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [15:0] addr_q[$];
    logic [6:0]  lvl_q[$];
    int          data_mode = 0;
    bit          mon_on = 1'b0;
    int          extra = 0;
    int          t_prev = 0;
    int          t_last = 0;
    logic [6:0]  prev_lvl = 7'd0;
    bit          done = 1'b0;

    function automatic logic [7:0] byte_for(input logic [15:0] a);
        logic [7:0] p;
        p = a[7:0] * 8'd37;
        case (data_mode)
            1:       return 8'hFF;
            2:       return 8'h00;
            default: return p ^ 8'hA5 ^ a[15:8];
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Driver: pushes the expected fetch addresses and level steps of one sample.
    task automatic expect_sample(input int a, input int l, input int lv);
        logic [15:0] ad;
        int cur;
        ad  = 16'hC000 + 16'(a * 64);
        cur = lv;
        for (int i = 0; i < l * 16 + 1; i++) begin
            logic [7:0] b;
            addr_q.push_back(ad);
            b = byte_for(ad);
            for (int k = 0; k < 8; k++) begin
                int nxt;
                nxt = b[k] ? cur + 2 : cur - 2;
                if (nxt >= 0 && nxt <= 127) begin
                    cur = nxt;
                    lvl_q.push_back(7'(cur));
                end
            end
            ad = (ad == 16'hFFFF) ? 16'h8000 : ad + 16'd1;
        end
    endtask

    // Monitor: answers fetches and scores addresses and level steps.
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                dma_gnt = 1'b0;
            end else begin
                if (dma_gnt) begin
                    dma_gnt = 1'b0;
                end else if (dma_req) begin
                    if (addr_q.size() > 0) begin
                        logic [15:0] e;
                        e = addr_q.pop_front();
                        check(dma_addr == e, "R3/R5 fetch address", dma_addr, e);
                    end else begin
                        extra++;
                    end
                    dma_data = byte_for(dma_addr);
                    dma_gnt  = 1'b1;
                end
                if (level != prev_lvl) begin
                    t_prev = t_last;
                    t_last = cyc;
                    if (mon_on) begin
                        if (lvl_q.size() > 0) begin
                            logic [6:0] e2;
                            e2 = lvl_q.pop_front();
                            check(level == e2, "R6 level step", level, e2);
                        end else begin
                            check(1'b0, "R6 unexpected level step", level, prev_lvl);
                        end
                    end
                end
                prev_lvl = level;
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic enw(input logic v);
        @(negedge clk);
        en_wr = 1'b1; en_val = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic direct(input logic [6:0] v);
        mon_on = 1'b0;
        wr(2'd1, {1'b0, v});
        @(negedge clk);
    endtask

    task automatic wait_done();
        while (addr_q.size() != 0 || lvl_q.size() != 0) @(negedge clk);
        repeat (300) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        logic [6:0] l0;
        int e0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(level == 7'd0, "R1 level", level, 0);
        check(dma_req == 1'b0, "R1 dma_req", dma_req, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(active == 1'b0, "R1 active", active, 0);
        rst = 1'b0;

        // R2 direct load
        wr(2'd1, 8'd64);
        check(level == 7'd64, "R2 direct load", level, 64);
        @(negedge clk);

        // R3 R4 R5 R6 R7: hashed 17-byte sample, irq enabled
        wr(2'd0, 8'h8F);
        wr(2'd2, 8'h10);
        wr(2'd3, 8'h01);
        expect_sample(16, 1, 64);
        mon_on = 1'b1;
        enw(1'b1);
        check(active == 1'b1, "R3 active after enable", active, 1);
        wait_done();
        check(irq == 1'b1, "R7 irq at sample end", irq, 1);
        check(active == 1'b0, "R3 active after last fetch", active, 0);
        check(extra == 0, "R3 fetch count", extra, 0);
        // R12 silence holds level
        l0 = level;
        repeat (300) @(negedge clk);
        check(level == l0, "R12 level held while silent", level, l0);
        check(irq == 1'b1, "R7 irq persists", irq, 1);
        wr(2'd0, 8'h8F);
        check(irq == 1'b1, "R7 ctrl write keeping enable", irq, 1);
        enw(1'b0);
        check(irq == 1'b0, "R7 enable write clears irq", irq, 0);

        // R11 clearing IRQ enable clears irq
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        expect_sample(0, 0, int'(level));
        enw(1'b1);
        wait_done();
        check(irq == 1'b1, "R7 irq one-byte sample", irq, 1);
        wr(2'd0, 8'h0F);
        check(irq == 1'b0, "R11 irq cleared by ctrl write", irq, 0);

        // R5 wrap: 65 bytes from 0xFFC0
        direct(7'd10);
        mon_on = 1'b1;
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'h04);
        expect_sample(255, 4, 10);
        enw(1'b1);
        wait_done();
        check(extra == 0, "R5 wrap fetch count", extra, 0);
        check(irq == 1'b0, "R7 no irq when disabled", irq, 0);

        // R6 upper clamp and R9 rate 15
        direct(7'd0);
        data_mode = 1;
        wr(2'd0, 8'h0F);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h01);
        expect_sample(0, 1, 0);
        mon_on = 1'b1;
        enw(1'b1);
        wait_done();
        check(level == 7'd126, "R6 upper clamp", level, 126);
        check(t_last - t_prev == (54 >> TSH), "R9 period index 15", t_last - t_prev, 54 >> TSH);

        // R9 rate 13
        direct(7'd100);
        wr(2'd0, 8'h0D);
        wr(2'd3, 8'h00);
        expect_sample(0, 0, 100);
        mon_on = 1'b1;
        enw(1'b1);
        wait_done();
        check(level == 7'd116, "R6 eight rising steps", level, 116);
        check(t_last - t_prev == (84 >> TSH), "R9 period index 13", t_last - t_prev, 84 >> TSH);

        // R6 lower clamp
        direct(7'd5);
        data_mode = 2;
        wr(2'd0, 8'h0F);
        expect_sample(0, 0, 5);
        mon_on = 1'b1;
        enw(1'b1);
        wait_done();
        check(level == 7'd1, "R6 lower clamp", level, 1);

        // R8 loop
        mon_on = 1'b0;
        data_mode = 0;
        wr(2'd0, 8'hCF);
        for (int i = 0; i < 4; i++) addr_q.push_back(16'hC000);
        enw(1'b1);
        while (addr_q.size() != 0) @(negedge clk);
        repeat (100) @(negedge clk);
        check(irq == 1'b0, "R8 no irq when looping", irq, 0);
        check(active == 1'b1, "R8 still active when looping", active, 1);
        enw(1'b0);
        check(active == 1'b0, "R10 disable clears count", active, 0);
        repeat (20) @(negedge clk);
        e0 = extra;
        repeat (400) @(negedge clk);
        check(extra == e0, "R10 no fetch after disable", extra, e0);
        check(dma_req == 1'b0, "R10 request low after disable", dma_req, 0);

        // R10 buffered and shifting bytes finish after disable
        direct(7'd0);
        data_mode = 1;
        wr(2'd0, 8'h0F);
        wr(2'd3, 8'h01);
        extra = 0;
        enw(1'b1);
        while (extra < 2) @(negedge clk);
        enw(1'b0);
        repeat (400) @(negedge clk);
        check(level == 7'd32, "R10 two bytes play out", level, 32);
        check(extra == 2, "R10 fetching stopped", extra, 2);
        check(active == 1'b0, "R10 inactive", active, 0);

        finish_run();
    end

endmodule